// File: doc/BRIEF.md
# Port Access Permission Checker

This block decides whether a task may touch an I/O port range of one, two or four bytes. A requester presents a port number, an access-width code, the byte address of the current task record and a flag that marks an old-format record. For an old-format record the answer is an immediate refusal. For any other record the block looks up the permission bitmap: it reads a 16-bit bitmap pointer out of the task record, then reads the bitmap bytes that cover the requested ports, and finally reports allow or deny with a one-cycle completion strobe.

All memory traffic goes over a minimal read port: a one-cycle read strobe with an address, answered later by a response-valid strobe carrying 16 bits. The first byte of a response sits in the low half. Every read fetches two adjacent bytes, so a port range that straddles a bitmap byte boundary is judged from a single 16-bit window. Exceptions, privilege comparison and bitmap-limit checks are left to the surrounding logic.

Top module: `ioperm_gate`

## Requirements
- R1: After synchronous reset `busy`, `mem_rd`, `done` and `allow` are all 0.
- R2: A request with `req_legacy` = 1 issues no memory read; `done` rises two cycles after the cycle in which the request is accepted, with `allow` = 0.
- R3: For a request with `req_legacy` = 0, the first read is issued in the cycle after acceptance at address `req_base` + 66; its response is taken as the bitmap pointer with `mem_rdata[7:0]` as the low byte and `mem_rdata[15:8]` as the high byte.
- R4: The second read goes to the pointer plus the port number shifted right by three bits (zero-extended).
- R5: The check mask is 1 for width code 0, 3 for width code 1 and 15 for width codes 2 and 3, shifted left by `req_port[2:0]`; it is applied to a 16-bit window whose bits 7:0 are the byte at the bitmap address and bits 15:8 the next byte.
- R6: `allow` is 1 only when every window bit selected by the mask is 0, including masks that reach into the second byte; bits outside the mask have no effect.
- R7: Each read waits for `mem_rvalid`, however many cycles that takes; `mem_rdata` is ignored in cycles without `mem_rvalid`.
- R8: `done` is high for exactly one cycle, two cycles after the cycle that carries the bitmap response; `allow` is 0 whenever `done` is 0.
- R9: While `busy` is 1, `req_valid` is ignored and the check in progress completes with its own arguments.
- R10: `mem_rd` is a one-cycle strobe that occurs only while `busy` is 1; a check of a new-format record makes exactly two reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a check (sampled while idle) |
| req_port | input | PW (16) | Port number of the access |
| req_width | input | 2 | Width code: 0 byte, 1 word, 2 or 3 doubleword |
| req_base | input | AW (32) | Byte address of the task record |
| req_legacy | input | 1 | 1 = old-format record, always refused |
| busy | output | 1 | A check is in progress |
| mem_rd | output | 1 | Read strobe, one cycle per read |
| mem_addr | output | AW (32) | Byte address of the read |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 16 | Two bytes starting at the read address, first byte low |
| done | output | 1 | One-cycle completion strobe |
| allow | output | 1 | Verdict, valid with `done` |

## Verification
The bound checker watches, on every cycle, the pulse shape of `mem_rd` and `done`, that reads happen only while busy, that `allow` never appears without `done`, that the first read targets the record base plus 66, and that an old-format request is refused two cycles later without a read. Whether the verdict is right depends on memory contents, the window across two bytes, the mask width and shift, the byte order of the pointer and response latency, so those only show in the bench's scenarios, which predict each verdict and the read addresses from a model memory and compare them as each check completes.

// File: rtl/ioperm_pkg.sv
package ioperm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PTR    = 2'd1,
    ST_MAP    = 2'd2,
    ST_DECIDE = 2'd3
  } chk_state_e;

  typedef enum logic [1:0] {
    WID_BYTE  = 2'd0,
    WID_WORD  = 2'd1,
    WID_DWORD = 2'd2,
    WID_DWALT = 2'd3
  } acc_width_e;

  // number of consecutive ports covered by one access
  function automatic logic [2:0] width_span(input logic [1:0] code);
    case (code)
      WID_BYTE: width_span = 3'd1;
      WID_WORD: width_span = 3'd2;
      default:  width_span = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/ioperm_mask.sv
module ioperm_mask #(
  parameter int WIN = 16,
  parameter int SHW = 3
) (
  input  logic [1:0]     width_code,
  input  logic [SHW-1:0] shift,
  output logic [WIN-1:0] mask
);
  import ioperm_pkg::*;

  localparam int IW = $clog2(WIN) + 2;

  logic [IW-1:0] span_w;
  logic [IW-1:0] shift_w;

  assign span_w  = IW'(width_span(width_code));
  assign shift_w = IW'(shift);

  // each window bit is selected when it lies in [shift, shift + span)
  generate
    for (genvar i = 0; i < WIN; i++) begin : g_bit
      localparam logic [IW-1:0] POS = IW'(i);
      assign mask[i] = (POS >= shift_w) && ((POS - shift_w) < span_w);
    end
  endgenerate

endmodule

// File: rtl/ioperm_addr.sv
module ioperm_addr #(
  parameter int AW      = 32,
  parameter int PW      = 16,
  parameter int PTRW    = 16,
  parameter int PTR_OFS = 66,
  parameter int SHW     = 3
) (
  input  logic [AW-1:0]   base,
  input  logic [PW-1:0]   port,
  input  logic [PTRW-1:0] ptr,
  output logic [AW-1:0]   ptr_addr,
  output logic [AW-1:0]   map_addr
);
  localparam int IDXW = PW - SHW;

  logic [IDXW-1:0] byte_idx;

  assign byte_idx = port[PW-1:SHW];
  assign ptr_addr = base + AW'(PTR_OFS);
  assign map_addr = AW'(ptr) + AW'(byte_idx);

endmodule

// File: rtl/ioperm_ctrl.sv
module ioperm_ctrl #(
  parameter int AW  = 32,
  parameter int PW  = 16,
  parameter int DW  = 16,
  parameter int SHW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [PW-1:0]  req_port,
  input  logic [1:0]     req_width,
  input  logic           req_legacy,
  input  logic [AW-1:0]  ptr_addr,
  input  logic [AW-1:0]  map_addr,
  input  logic [DW-1:0]  mask,
  input  logic           mem_rvalid,
  input  logic [DW-1:0]  mem_rdata,
  output logic [PW-1:0]  port_q,
  output logic [1:0]     width_q,
  output logic           busy,
  output logic           mem_rd,
  output logic [AW-1:0]  mem_addr,
  output logic           done,
  output logic           allow
);
  import ioperm_pkg::*;

  chk_state_e     state;
  logic           legacy_q;
  logic [DW-1:0]  window_q;
  logic           clear_bits;

  assign clear_bits = ~|(window_q & mask);
  assign busy       = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      legacy_q <= 1'b0;
      window_q <= '0;
      port_q   <= '0;
      width_q  <= '0;
      mem_rd   <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      allow    <= 1'b0;
    end else begin
      mem_rd <= 1'b0;
      done   <= 1'b0;
      allow  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            port_q   <= req_port;
            width_q  <= req_width;
            legacy_q <= req_legacy;
            if (req_legacy) begin
              state <= ST_DECIDE;
            end else begin
              state    <= ST_PTR;
              mem_rd   <= 1'b1;
              mem_addr <= ptr_addr;
            end
          end
        end
        ST_PTR: begin
          if (mem_rvalid) begin
            state    <= ST_MAP;
            mem_rd   <= 1'b1;
            mem_addr <= map_addr;
          end
        end
        ST_MAP: begin
          if (mem_rvalid) begin
            window_q <= mem_rdata;
            state    <= ST_DECIDE;
          end
        end
        ST_DECIDE: begin
          done  <= 1'b1;
          allow <= !legacy_q && clear_bits;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ioperm_gate.sv
module ioperm_gate #(
  parameter int AW      = 32,
  parameter int PW      = 16,
  parameter int PTR_OFS = 66
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [PW-1:0] req_port,
  input  logic [1:0]    req_width,
  input  logic [AW-1:0] req_base,
  input  logic          req_legacy,
  output logic          busy,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [15:0]   mem_rdata,
  output logic          done,
  output logic          allow
);
  localparam int BYTEW = 8;
  localparam int DW    = 2 * BYTEW;
  localparam int SHW   = $clog2(BYTEW);

  logic [PW-1:0] port_q;
  logic [1:0]    width_q;
  logic [AW-1:0] ptr_addr;
  logic [AW-1:0] map_addr;
  logic [DW-1:0] mask;

  ioperm_addr #(
    .AW(AW), .PW(PW), .PTRW(DW), .PTR_OFS(PTR_OFS), .SHW(SHW)
  ) u_addr (
    .base     (req_base),
    .port     (port_q),
    .ptr      (mem_rdata),
    .ptr_addr (ptr_addr),
    .map_addr (map_addr)
  );

  ioperm_mask #(
    .WIN(DW), .SHW(SHW)
  ) u_mask (
    .width_code (width_q),
    .shift      (port_q[SHW-1:0]),
    .mask       (mask)
  );

  ioperm_ctrl #(
    .AW(AW), .PW(PW), .DW(DW), .SHW(SHW)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_port   (req_port),
    .req_width  (req_width),
    .req_legacy (req_legacy),
    .ptr_addr   (ptr_addr),
    .map_addr   (map_addr),
    .mask       (mask),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .port_q     (port_q),
    .width_q    (width_q),
    .busy       (busy),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .done       (done),
    .allow      (allow)
  );

endmodule

// File: rtl/ioperm_gate_chk.sv
module ioperm_gate_chk #(
  parameter int AW      = 32,
  parameter int PTR_OFS = 66
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [AW-1:0] req_base,
  input logic          req_legacy,
  input logic          busy,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic          allow
);

  // R2
  legacy_deny_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid && req_legacy) |=> ##1 (done && !allow));

  // R2
  legacy_noread_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid && req_legacy) |=> (busy && !mem_rd));

  // R3
  ptr_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid && !req_legacy) |=>
      (mem_rd && mem_addr == $past(req_base) + AW'(PTR_OFS)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  allow_qual_chk: assert property (@(posedge clk) disable iff (rst)
    allow |-> done);

  // R10
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  // R10
  rd_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> busy);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && req_valid) |=> (busy || done));

endmodule

bind ioperm_gate ioperm_gate_chk #(.AW(AW), .PTR_OFS(PTR_OFS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_base   (req_base),
  .req_legacy (req_legacy),
  .busy       (busy),
  .mem_rd     (mem_rd),
  .mem_addr   (mem_addr),
  .done       (done),
  .allow      (allow)
);

// File: tb/ioperm_gate_test.sv
`timescale 1ns/1ps
module ioperm_gate_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_port = '0;
  logic [1:0]  req_width = '0;
  logic [31:0] req_base = '0;
  logic        req_legacy = 1'b0;
  logic        busy, mem_rd, done, allow;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = 16'hA5A5;

  always #2.5 clk = ~clk;

  ioperm_gate uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_port(req_port),
    .req_width(req_width), .req_base(req_base), .req_legacy(req_legacy),
    .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .allow(allow)
  );

  int compared = 0;
  int mismatched = 0;

  logic [7:0]  mem [0:1023];
  logic [31:0] rd_log [0:255];
  int          rd_count = 0;
  int          latency = 0;
  int          pend_cnt = 0;
  bit          pend = 0;
  logic [31:0] pend_addr = '0;
  int          rv_age = 100;
  int          completed = 0;

  // scoreboard queues
  bit          q_allow [$];
  bit          q_legacy [$];
  string       q_tag [$];
  int          q_mark [$];
  logic [31:0] q_pa [$];
  logic [31:0] q_ma [$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd16(input logic [31:0] a);
    logic [9:0] lo;
    lo = a[9:0];
    return {mem[lo + 10'd1], mem[lo]};
  endfunction

  // memory model, response monitor and scoreboard compare
  always @(negedge clk) begin
    rv_age++;
    if (done) begin
      if (q_allow.size() == 0) begin
        check("R8 unexpected done", 32'd1, 32'd0);
      end else begin
        bit exp_al, leg;
        string tg;
        int mark;
        logic [31:0] pa, ma;
        exp_al = q_allow.pop_front();
        leg    = q_legacy.pop_front();
        tg     = q_tag.pop_front();
        mark   = q_mark.pop_front();
        pa     = q_pa.pop_front();
        ma     = q_ma.pop_front();
        check({tg, " verdict"}, 32'(allow), 32'(exp_al));
        check("R10 read count", 32'(rd_count - mark), leg ? 32'd0 : 32'd2);
        if (!leg) begin
          check("R3 pointer address", rd_log[mark[7:0]], pa);
          check("R4 bitmap address", rd_log[8'(mark + 1)], ma);
          check("R8 done after response", 32'(rv_age), 32'd2);
        end
      end
      completed++;
    end
    if (!done) begin
      if (allow !== 1'b0) check("R8 allow without done", 32'(allow), 32'd0);
    end
    mem_rvalid = 1'b0;
    mem_rdata  = 16'hA5A5;
    if (pend) begin
      if (pend_cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = rd16(pend_addr);
        pend       = 0;
        rv_age     = 0;
      end else begin
        pend_cnt--;
      end
    end
    if (mem_rd) begin
      rd_log[rd_count[7:0]] = mem_addr;
      rd_count++;
      pend      = 1;
      pend_cnt  = latency;
      pend_addr = mem_addr;
    end
  end

  // driver: predict from the requirements and push, then launch
  task automatic run(input string tag, input logic [31:0] base, input logic [15:0] port,
                     input logic [1:0] w, input bit leg, input int lat, input bit poke);
    logic [31:0] pa, ma;
    logic [15:0] ptr, win, msk;
    bit          al;
    int          target;
    pa  = base + 32'd66;
    ptr = rd16(pa);
    ma  = 32'(ptr) + 32'(port >> 3);
    win = rd16(ma);
    msk = ((w == 2'd0) ? 16'h1 : (w == 2'd1) ? 16'h3 : 16'hF) << port[2:0];
    al  = !leg && ((win & msk) == 16'h0);
    latency = lat;
    q_allow.push_back(al);
    q_legacy.push_back(leg);
    q_tag.push_back(tag);
    q_mark.push_back(rd_count);
    q_pa.push_back(pa);
    q_ma.push_back(ma);
    target = completed + 1;
    @(negedge clk);
    req_valid = 1'b1; req_port = port; req_width = w; req_base = base; req_legacy = leg;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      // R9: competing requests while busy must be ignored
      req_valid = 1'b1; req_port = 16'h0021; req_width = 2'd0;
      req_base = 32'h0000_0380; req_legacy = 1'b1;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (completed < target) @(negedge clk);
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    // record A at 0x300: pointer 0x0100
    mem[10'h342] = 8'h00; mem[10'h343] = 8'h01;
    // record B at 0x380: pointer 0x0120 (byte order matters)
    mem[10'h3C2] = 8'h20; mem[10'h3C3] = 8'h01;
    mem[10'h104] = 8'h02;        // port 0x21 denied
    mem[10'h109] = 8'h21;        // ports 0x48 and 0x4D denied
    mem[10'h121] = 8'h01;        // record B, port 0x08 denied

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset",   32'(busy),   32'd0);
    check("R1 mem_rd after reset", 32'(mem_rd), 32'd0);
    check("R1 done after reset",   32'(done),   32'd0);
    check("R1 allow after reset",  32'(allow),  32'd0);

    run("R2 old format",           32'h300, 16'h0020, 2'd0, 1'b1, 0, 1'b0);
    run("R6 byte clear",           32'h300, 16'h0020, 2'd0, 1'b0, 0, 1'b0);
    run("R6 byte set",             32'h300, 16'h0021, 2'd0, 1'b0, 0, 1'b0);
    run("R5 word crossing denied", 32'h300, 16'h0047, 2'd1, 1'b0, 0, 1'b0);
    run("R5 word in byte allowed", 32'h300, 16'h0046, 2'd1, 1'b0, 1, 1'b0);
    run("R6 dword crossing",       32'h300, 16'h0045, 2'd2, 1'b0, 0, 1'b0);
    run("R6 dword outside set bit",32'h300, 16'h0049, 2'd2, 1'b0, 2, 1'b0);
    run("R5 width code 3",         32'h300, 16'h004A, 2'd3, 1'b0, 0, 1'b0);
    run("R3 little-endian pointer",32'h380, 16'h0008, 2'd0, 1'b0, 0, 1'b0);
    run("R7 slow responses",       32'h300, 16'h0049, 2'd2, 1'b0, 6, 1'b0);
    run("R7 slow deny",            32'h300, 16'h0021, 2'd0, 1'b0, 5, 1'b0);
    run("R9 busy ignore",          32'h300, 16'h0020, 2'd0, 1'b0, 3, 1'b1);
    run("R2 old format again",     32'h380, 16'h0008, 2'd2, 1'b1, 0, 1'b0);

    check("R9 no leftover results", 32'(q_allow.size()), 32'd0);
    repeat (4) @(negedge clk);
    check("R9 idle after checks", 32'(busy), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule